// File: doc/BRIEF.md
# DRAM Cache Line Fill Sequencer

This block serves one cache-line miss at a time. It takes the byte address of a 64-byte line and reads the line from a DIMM built from eight single-bank chips of 1 MB each. It issues one read command after another on the DIMM command channel. It collects the byte lanes that come back and presents the assembled 512-bit line together with a one-cycle completion pulse.

A mode bit, sampled together with the request, selects how addresses are spread over the chips:

- **Blocked mode.** Every 1 MB region belongs to a single chip. The line therefore needs 64 narrow reads, and only that chip's byte lane is kept from each read.
- **Interleaved mode.** Each byte lives on chip (address mod 8). Eight full-width reads at consecutive columns fill the line.

Row and column are derived differently in each mode. A request whose address is not aligned to 64 bytes is rejected with an error pulse and causes no DIMM traffic.

Top module: `line_fill_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `fill_done` and `fill_err` are 0.
- R2: A request accepted with `req_addr[5:0]` not zero raises `fill_err` for exactly the following cycle. It issues no command, and `req_ready` stays 1.
- R3: In blocked mode (`req_mode`=0), every command carries row = `req_addr[19:8]`. The first command carries column = `req_addr[7:0]`.
- R4: In blocked mode exactly 64 commands are issued, and the column rises by one from each command to the next.
- R5: In blocked mode, line byte i (bits 8i+7..8i of `fill_line`) equals the lane of chip c = `req_addr[22:20]` (bits 8c+7..8c of `rd_data`) from the i-th returned word. The other lanes have no effect.
- R6: In interleaved mode (`req_mode`=1), there are exactly 8 commands. Their row is `req_addr[22:11]`, and their columns run from `req_addr[10:3]` up in steps of one.
- R7: In interleaved mode, line byte 8k+j equals bits 8j+7..8j of the k-th returned word.
- R8: `cmd_valid` stays high, with `cmd_row` and `cmd_col` unchanged, until `cmd_ready` is sampled high. No further command is raised until a word has been returned with `rd_valid`.
- R9: `fill_done` is high for exactly one cycle: the cycle after the edge that samples the last `rd_valid`. `fill_line` holds the complete line in that cycle.
- R10: `req_ready` is 1 only while no fill is in progress. A `req_valid` seen while it is 0 is ignored.
- R11: `rd_valid` pulses that arrive while no command is awaiting data leave `fill_line` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line request strobe |
| req_addr | input | 23 | Byte address of the line |
| req_mode | input | 1 | 0 blocked mapping, 1 interleaved mapping |
| req_ready | output | 1 | Idle, request can be taken |
| fill_done | output | 1 | One-cycle completion pulse |
| fill_err | output | 1 | One-cycle misaligned-request pulse |
| fill_line | output | 512 | Assembled line, byte i at bits 8i+7..8i |
| cmd_valid | output | 1 | Read command valid |
| cmd_ready | input | 1 | DIMM accepts command |
| cmd_row | output | 12 | Row of the read |
| cmd_col | output | 8 | Column of the read |
| rd_valid | input | 1 | Returned word strobe |
| rd_data | input | 64 | Returned word, chip j on bits 8j+7..8j |

## Verification
Accepting a request moves the controller to its command state at that same edge, so `cmd_valid` is due one cycle later. `fill_err` is likewise due one cycle after a misaligned acceptance. `fill_done` and the last line byte both appear one cycle after the edge that samples the final `rd_valid`. The bench keeps a behavioural model that updates on the same rising edges from the same inputs. It compares ready, command, done and error outputs against that model on every falling edge. It compares the full line and the command count in the cycle where the model expects completion.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fill_state_e;

  typedef enum logic {
    MAP_BLOCKED = 1'b0,
    MAP_SPREAD  = 1'b1
  } map_mode_e;
endpackage

// File: rtl/lfs_addr_map.sv
module lfs_addr_map #(
  parameter int CHIPS_LG      = 3,
  parameter int CHIP_BYTES_LG = 20,
  parameter int ROW_BYTES_LG  = 8,
  parameter int LINE_BYTES_LG = 6,
  localparam int ADDR_W = CHIP_BYTES_LG + CHIPS_LG,
  localparam int ROW_W  = CHIP_BYTES_LG - ROW_BYTES_LG,
  localparam int COL_W  = ROW_BYTES_LG
) (
  input  logic [ADDR_W-1:0]   addr,
  input  lfs_pkg::map_mode_e  mode,
  output logic                aligned,
  output logic [CHIPS_LG-1:0] chip,
  output logic [ROW_W-1:0]    row,
  output logic [COL_W-1:0]    col
);
  logic [CHIP_BYTES_LG-1:0] spread_loc;

  always_comb begin
    spread_loc = addr[ADDR_W-1:CHIPS_LG];
    aligned    = (addr[LINE_BYTES_LG-1:0] == '0);
    chip       = addr[ADDR_W-1:CHIP_BYTES_LG];
    if (mode == lfs_pkg::MAP_SPREAD) begin
      row = spread_loc[CHIP_BYTES_LG-1:ROW_BYTES_LG];
      col = spread_loc[ROW_BYTES_LG-1:0];
    end else begin
      row = addr[CHIP_BYTES_LG-1:ROW_BYTES_LG];
      col = addr[ROW_BYTES_LG-1:0];
    end
  end
endmodule

// File: rtl/lfs_ctrl.sv
module lfs_ctrl #(
  parameter int IDX_W  = 6,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int CHIP_W = 3,
  parameter int N_BLK  = 64,
  parameter int N_SPR  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_aligned,
  input  lfs_pkg::map_mode_e req_mode,
  input  logic [ROW_W-1:0]   req_row,
  input  logic [COL_W-1:0]   req_col,
  input  logic [CHIP_W-1:0]  req_chip,
  input  logic               cmd_ready,
  input  logic               rd_valid,
  output logic               req_ready,
  output logic               cmd_valid,
  output logic [ROW_W-1:0]   cmd_row,
  output logic [COL_W-1:0]   cmd_col,
  output logic               fill_we,
  output logic [IDX_W-1:0]   fill_idx,
  output lfs_pkg::map_mode_e fill_mode,
  output logic [CHIP_W-1:0]  fill_lane,
  output logic               done,
  output logic               err
);
  import lfs_pkg::*;

  fill_state_e        state_q, state_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;
  logic [CHIP_W-1:0]  chip_q;
  map_mode_e          mode_q;
  logic               done_q, done_d, err_q, err_d, load, last;

  always_comb begin
    last = (mode_q == MAP_SPREAD) ? (cnt_q == IDX_W'(N_SPR - 1))
                                  : (cnt_q == IDX_W'(N_BLK - 1));
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    load    = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        if (req_aligned) begin
          state_d = ST_ISSUE;
          cnt_d   = '0;
          load    = 1'b1;
        end else begin
          err_d = 1'b1;
        end
      end
      ST_ISSUE: if (cmd_ready) state_d = ST_WAIT;
      ST_WAIT: if (rd_valid) begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          cnt_d   = '0;
        end else begin
          state_d = ST_ISSUE;
          cnt_d   = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      chip_q  <= '0;
      mode_q  <= MAP_BLOCKED;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (load) begin
        row_q  <= req_row;
        col_q  <= req_col;
        chip_q <= req_chip;
        mode_q <= req_mode;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_row   = row_q;
  assign cmd_col   = col_q + COL_W'(cnt_q);
  assign fill_we   = (state_q == ST_WAIT) && rd_valid;
  assign fill_idx  = cnt_q;
  assign fill_mode = mode_q;
  assign fill_lane = chip_q;
  assign done      = done_q;
  assign err       = err_q;

  // R8: a stalled command keeps its address
  a_r8_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_row) && $stable(cmd_col));

  // R8: after acceptance, no new command until data returns
  a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: rejection leaves the block idle
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> req_ready && !cmd_valid && !done);

  // R10: never ready while a command is pending
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  // R6: the spread-mode index stays below its read count
  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && fill_mode == MAP_SPREAD |-> fill_idx < IDX_W'(N_SPR));
endmodule

// File: rtl/lfs_line_buf.sv
module lfs_line_buf #(
  parameter int CHIPS_LG      = 3,
  parameter int LANE_W        = 8,
  parameter int LINE_BYTES_LG = 6,
  localparam int CHIPS      = 1 << CHIPS_LG,
  localparam int LINE_BYTES = 1 << LINE_BYTES_LG,
  localparam int DATA_W     = CHIPS * LANE_W,
  localparam int LINE_W     = LINE_BYTES * LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  lfs_pkg::map_mode_e       mode,
  input  logic [LINE_BYTES_LG-1:0] idx,
  input  logic [CHIPS_LG-1:0]      lane,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [LINE_W-1:0]        line
);
  logic [LANE_W-1:0] sel_byte;

  always_comb sel_byte = rd_data[lane*LANE_W +: LANE_W];

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic              hit;
    logic [LANE_W-1:0] din;
    always_comb begin
      if (mode == lfs_pkg::MAP_SPREAD) begin
        hit = (idx == LINE_BYTES_LG'(b / CHIPS));
        din = rd_data[(b % CHIPS)*LANE_W +: LANE_W];
      end else begin
        hit = (idx == LINE_BYTES_LG'(b));
        din = sel_byte;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line[b*LANE_W +: LANE_W] <= '0;
      else if (we && hit) line[b*LANE_W +: LANE_W] <= din;
    end
  end
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int CHIPS_LG      = 3,
  parameter int CHIP_BYTES_LG = 20,
  parameter int ROW_BYTES_LG  = 8,
  parameter int LINE_BYTES_LG = 6,
  parameter int LANE_W        = 8,
  localparam int ADDR_W = CHIP_BYTES_LG + CHIPS_LG,
  localparam int ROW_W  = CHIP_BYTES_LG - ROW_BYTES_LG,
  localparam int COL_W  = ROW_BYTES_LG,
  localparam int CHIPS  = 1 << CHIPS_LG,
  localparam int DATA_W = CHIPS * LANE_W,
  localparam int LINE_W = (1 << LINE_BYTES_LG) * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_mode,
  output logic              req_ready,
  output logic              fill_done,
  output logic              fill_err,
  output logic [LINE_W-1:0] fill_line,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data
);
  import lfs_pkg::*;

  map_mode_e                mode_in, fill_mode;
  logic                     aligned, fill_we;
  logic [CHIPS_LG-1:0]      map_chip, fill_lane;
  logic [ROW_W-1:0]         map_row;
  logic [COL_W-1:0]         map_col;
  logic [LINE_BYTES_LG-1:0] fill_idx;

  assign mode_in = map_mode_e'(req_mode);

  lfs_addr_map #(
    .CHIPS_LG(CHIPS_LG), .CHIP_BYTES_LG(CHIP_BYTES_LG),
    .ROW_BYTES_LG(ROW_BYTES_LG), .LINE_BYTES_LG(LINE_BYTES_LG)
  ) u_map (
    .addr(req_addr), .mode(mode_in), .aligned(aligned),
    .chip(map_chip), .row(map_row), .col(map_col)
  );

  lfs_ctrl #(
    .IDX_W(LINE_BYTES_LG), .ROW_W(ROW_W), .COL_W(COL_W), .CHIP_W(CHIPS_LG),
    .N_BLK(1 << LINE_BYTES_LG), .N_SPR((1 << LINE_BYTES_LG) / CHIPS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_aligned(aligned),
    .req_mode(mode_in), .req_row(map_row), .req_col(map_col), .req_chip(map_chip),
    .cmd_ready(cmd_ready), .rd_valid(rd_valid), .req_ready(req_ready),
    .cmd_valid(cmd_valid), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .fill_we(fill_we), .fill_idx(fill_idx), .fill_mode(fill_mode),
    .fill_lane(fill_lane), .done(fill_done), .err(fill_err)
  );

  lfs_line_buf #(
    .CHIPS_LG(CHIPS_LG), .LANE_W(LANE_W), .LINE_BYTES_LG(LINE_BYTES_LG)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .we(fill_we), .mode(fill_mode), .idx(fill_idx),
    .lane(fill_lane), .rd_data(rd_data), .line(fill_line)
  );
endmodule

// File: tb/sim_line_fill_seq.sv
`timescale 1ns/1ps
module sim_line_fill_seq;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_mode, req_ready, fill_done, fill_err;
  logic [22:0]  req_addr;
  logic [511:0] fill_line;
  logic         cmd_valid, cmd_ready, rd_valid;
  logic [11:0]  cmd_row;
  logic [7:0]   cmd_col;
  logic [63:0]  rd_data;

  always #4 clk = ~clk;

  line_fill_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mode(req_mode), .req_ready(req_ready), .fill_done(fill_done),
    .fill_err(fill_err), .fill_line(fill_line), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  // behavioural model state
  bit           m_busy = 0, m_wait = 0, m_mode = 0, exp_done = 0, exp_err = 0;
  int           m_k = 0, m_n = 0, m_row = 0, m_col0 = 0, m_chip = 0;
  logic [511:0] exp_line = '0;
  bit           pend = 0;
  int           dly = 0, hs_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    exp_done = 0;
    exp_err  = 0;
    if (!rst_n) begin
      m_busy = 0; m_wait = 0; m_k = 0; pend = 0;
    end else if (!m_busy) begin
      if (req_valid) begin
        if (req_addr % 64 != 0) exp_err = 1;
        else begin
          m_busy = 1; m_wait = 0; m_k = 0; m_mode = req_mode;
          if (req_mode) begin
            m_n = 8; m_row = (req_addr / 8) / 256; m_col0 = (req_addr / 8) % 256;
          end else begin
            m_n = 64; m_row = (req_addr % 1048576) / 256; m_col0 = req_addr % 256;
            m_chip = req_addr / 1048576;
          end
        end
      end
    end else if (!m_wait) begin
      if (cmd_ready) begin
        m_wait = 1; pend = 1; dly = $urandom_range(0, 2);
      end
    end else if (rd_valid) begin
      if (m_mode) exp_line[64*m_k +: 64] = rd_data;
      else exp_line[8*m_k +: 8] = rd_data[8*m_chip +: 8];
      m_k++;
      m_wait = 0;
      if (m_k == m_n) begin
        m_busy = 0; exp_done = 1;
      end
    end
  end

  // checks against the model, then DIMM-side driving
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
    if (rst_n) begin
      chk(req_ready == !m_busy, "R10 ready", req_ready, !m_busy);
      chk(cmd_valid == (m_busy && !m_wait), "R8 cmd_valid", cmd_valid, m_busy && !m_wait);
      if (m_busy && !m_wait) begin
        chk(cmd_row == 12'(m_row), m_mode ? "R6 row" : "R3 row", cmd_row, 12'(m_row));
        chk(cmd_col == 8'((m_col0 + m_k) % 256), m_mode ? "R6 col" : "R4 col",
            cmd_col, 8'((m_col0 + m_k) % 256));
      end
      chk(fill_done == exp_done, "R9 done", fill_done, exp_done);
      chk(fill_err == exp_err, "R2 err", fill_err, exp_err);
      if (exp_done) begin
        chk(fill_line == exp_line, m_mode ? "R7 line R11" : "R5 line R11",
            fill_line, exp_line);
        chk(hs_cnt == m_n, m_mode ? "R6 count" : "R4 count", hs_cnt, m_n);
        hs_cnt = 0;
      end
    end
    cmd_ready = ($urandom_range(0, 3) != 0);
    if (cmd_valid && cmd_ready && rst_n) hs_cnt++;
    rd_data = {$urandom, $urandom};
    if (pend) begin
      if (dly == 0) begin
        rd_valid = 1; pend = 0;
      end else begin
        rd_valid = 0; dly--;
      end
    end else begin
      rd_valid = ($urandom_range(0, 7) == 0);   // stray strobes, R11
    end
  end

  task automatic do_req(input logic [22:0] a, input bit md, input bit poke);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_addr = a; req_mode = md;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_valid = 1; req_addr = 23'h000040; req_mode = ~md;   // R10 ignored while busy
      @(negedge clk);
      req_valid = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [511:0] held;
    rst_n = 0; req_valid = 0; req_addr = '0; req_mode = 0;
    cmd_ready = 0; rd_valid = 0; rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(req_ready === 1'b1 && cmd_valid === 1'b0 && fill_done === 1'b0 && fill_err === 1'b0,
        "R1 reset", {req_ready, cmd_valid, fill_done, fill_err}, 4'b1000);
    @(negedge clk);
    do_req(23'h000000, 0, 0);
    do_req(23'h1A3C40, 0, 1);
    do_req(23'h7FFFC0, 0, 0);
    do_req(23'h000000, 1, 0);
    do_req(23'h012340, 1, 1);
    do_req(23'h7FFFC0, 1, 0);
    do_req(23'h000021, 0, 0);   // R2 misaligned
    do_req(23'h3FFFFF, 1, 0);   // R2 misaligned
    // R11: strobes while idle leave the line alone
    held = fill_line;
    repeat (20) @(negedge clk);
    chk(fill_line == held, "R11 idle", fill_line, held);
    do_req(23'h654300, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule